// File: doc/BRIEF.md
# Redundant-Pair Miss Hint Forwarder

Two cores run one program redundantly, with the leading core some distance ahead of the trailing one. This block takes the addresses that missed in the leading core's data cache and queues them. It then replays them, oldest first, as prefetch hints on the trailing cache's request port. A hint goes out only in a cycle when the trailing core makes no demand request. The trailing core's own demand address always reaches the cache unchanged. A wrong hint can therefore only cost an ordinary miss on the trailing side; it cannot corrupt any state.

The same block checks the committed load results of the two cores. Each committed value carries a program-order sequence tag. Leading-core commits wait in a small buffer. Each trailing commit is compared with the oldest waiting entry. A difference in tag or value, a trailing commit with nothing waiting, or a leading commit that finds the buffer full sets a sticky rollback request. A flush input, raised when the rollback is taken, empties both queues and clears the request.

Top module: `miss_hint_fwd`

## Requirements
- R1: Each leading-core miss address is queued and later issued on the cache port with `cache_req_pf`=1, in arrival order and with its address unchanged.
- R2: In any cycle with `dem_valid`=1, the port carries the demand request: `cache_req_valid`=1, `cache_req_addr`=`dem_addr`, and `cache_req_pf`=0. A hint waits while demands keep arriving.
- R3: A miss captured at one clock edge can appear as a hint in the very next cycle if that cycle has no demand. At most one hint is issued per idle cycle, and each queued address is issued exactly once.
- R4: The hint queue holds 8 addresses. A miss that arrives while the queue is full, judged by the occupancy at the start of the cycle, is discarded and increments `drop_count` by one. The counter saturates at its maximum.
- R5: A trailing commit whose tag and value equal those of the oldest waiting leading commit consumes that entry and leaves `rollback_req` at 0.
- R6: A trailing commit that differs from the oldest waiting leading commit in tag or in value sets `rollback_req` from the next cycle. The request stays set until a flush.
- R7: A trailing commit made when no leading commit is waiting sets `rollback_req`. A leading commit in the same cycle does not count as waiting.
- R8: The commit buffer holds 8 entries. A leading commit that arrives while the buffer is full is discarded and sets `rollback_req`.
- R9: `flush`=1 empties the hint queue and the commit buffer and clears `rollback_req` from the next cycle. Misses and commits presented in the flush cycle are ignored, and `drop_count` keeps its value.
- R10: After reset, no request or hint is on the port, `rollback_req`=0 and `drop_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clears both queues and the rollback request |
| lead_miss_valid | input | 1 | Leading data cache reports a miss |
| lead_miss_addr | input | ADDR_W | Address that missed |
| dem_valid | input | 1 | Trailing core demand request |
| dem_addr | input | ADDR_W | Trailing core's own computed address |
| cache_req_valid | output | 1 | Request on the trailing cache port |
| cache_req_addr | output | ADDR_W | Address of that request |
| cache_req_pf | output | 1 | 1 when the request is a forwarded hint |
| drop_count | output | DROP_W | Misses discarded on a full queue |
| lead_cmt_valid | input | 1 | Leading core commits a load result |
| lead_cmt_tag | input | TAG_W | Program-order sequence tag |
| lead_cmt_data | input | DATA_W | Committed value |
| trail_cmt_valid | input | 1 | Trailing core commits a load result |
| trail_cmt_tag | input | TAG_W | Program-order sequence tag |
| trail_cmt_data | input | DATA_W | Committed value |
| rollback_req | output | 1 | Sticky divergence flag |

## Verification
Corrupted queue pointers or occupancy show up on the next idle cycle of the trailing port. The symptoms are a hint with a wrong or repeated address, a missing hint, or a drop count that moves too early or too late. The scoreboard therefore compares every hint against the expected arrival order as it appears. A commit buffer state that is wrong shows up as a rollback request that appears, or fails to appear, one cycle after the trailing commit concerned. A flush that leaves stale entries behind is exposed by a matched commit pair after the flush, and by idle cycles with no hint on the port.

// File: rtl/miss_hint_pkg.sv
// Shared defaults and the comparator verdict type for the miss hint forwarder.
package miss_hint_pkg;
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_DATA_W     = 32;
    localparam int unsigned DEF_TAG_W      = 8;
    localparam int unsigned DEF_HINT_DEPTH = 8;
    localparam int unsigned DEF_CMT_DEPTH  = 8;
    localparam int unsigned DEF_DROP_W     = 16;

    typedef enum logic [1:0] {
        CMP_IDLE  = 2'd0,
        CMP_MATCH = 2'd1,
        CMP_DIFF  = 2'd2
    } cmp_verdict_e;
endpackage

// File: rtl/hint_sfifo.sv
// Synchronous FIFO with a first-word-fall-through read port.
// It assumes DEPTH is a power of two and at least 2. A push while full and a
// pop while empty are both ignored. clr empties the FIFO synchronously.
module hint_sfifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign rdata   = mem[rd_ptr];

    // Purpose: store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Purpose: advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hint_port_arb.sv
// Shares the trailing cache request port between demand and forwarded hints.
// A demand always wins. A hint is taken only in a cycle with no demand.
module hint_port_arb #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    input  logic              hint_avail,
    input  logic [ADDR_W-1:0] hint_addr,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_pf,
    output logic              hint_take
);
    // Purpose: select the demand when present, otherwise the oldest hint.
    always_comb begin
        hint_take = hint_avail & ~dem_valid;
        req_valid = dem_valid | hint_avail;
        req_pf    = hint_take;
        req_addr  = dem_valid ? dem_addr : hint_addr;
    end
endmodule

// File: rtl/commit_cmp.sv
// Buffers leading-core commits and compares each trailing commit with the
// oldest buffered one. It assumes both cores commit in program order.
// A mismatch, a trailing commit with nothing waiting, or an overflow of the
// buffer sets a sticky rollback flag, which only flush or reset clears.
module commit_cmp
    import miss_hint_pkg::*;
#(
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lead_valid,
    input  logic [TAG_W-1:0]  lead_tag,
    input  logic [DATA_W-1:0] lead_data,
    input  logic              trail_valid,
    input  logic [TAG_W-1:0]  trail_tag,
    input  logic [DATA_W-1:0] trail_data,
    output logic              rollback
);
    localparam int unsigned EW = TAG_W + DATA_W;

    logic [EW-1:0] head;
    logic          empty, full;
    logic          overflow;
    cmp_verdict_e  verdict;

    hint_sfifo #(.W(EW), .DEPTH(DEPTH)) u_cbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (lead_valid),
        .wdata ({lead_tag, lead_data}),
        .pop   (trail_valid),
        .rdata (head),
        .empty (empty),
        .full  (full)
    );

    // Purpose: judge the current trailing commit against the oldest entry.
    always_comb begin
        if (!trail_valid)                          verdict = CMP_IDLE;
        else if (empty)                            verdict = CMP_DIFF;
        else if (head == {trail_tag, trail_data})  verdict = CMP_MATCH;
        else                                       verdict = CMP_DIFF;
        overflow = lead_valid & full;
    end

    // Purpose: hold the rollback flag until it is flushed.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rollback <= 1'b0;
        end else if (verdict == CMP_DIFF || overflow) begin
            rollback <= 1'b1;
        end
    end
endmodule

// File: rtl/miss_hint_fwd.sv
// Top level: queues leading-core miss addresses, issues them as prefetch
// hints on idle cycles of the trailing cache port, counts misses discarded
// on a full queue, and compares committed load values of the two cores.
// It assumes the trailing cache accepts every request it is shown.
module miss_hint_fwd
    import miss_hint_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned TAG_W      = DEF_TAG_W,
    parameter int unsigned HINT_DEPTH = DEF_HINT_DEPTH,
    parameter int unsigned CMT_DEPTH  = DEF_CMT_DEPTH,
    parameter int unsigned DROP_W     = DEF_DROP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lead_miss_valid,
    input  logic [ADDR_W-1:0] lead_miss_addr,
    input  logic              dem_valid,
    input  logic [ADDR_W-1:0] dem_addr,
    output logic              cache_req_valid,
    output logic [ADDR_W-1:0] cache_req_addr,
    output logic              cache_req_pf,
    output logic [DROP_W-1:0] drop_count,
    input  logic              lead_cmt_valid,
    input  logic [TAG_W-1:0]  lead_cmt_tag,
    input  logic [DATA_W-1:0] lead_cmt_data,
    input  logic              trail_cmt_valid,
    input  logic [TAG_W-1:0]  trail_cmt_tag,
    input  logic [DATA_W-1:0] trail_cmt_data,
    output logic              rollback_req
);
    logic              hq_empty, hq_full, hint_take;
    logic [ADDR_W-1:0] hq_head;
    logic              miss_in;

    assign miss_in = lead_miss_valid & ~flush;

    hint_sfifo #(.W(ADDR_W), .DEPTH(HINT_DEPTH)) u_hq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .push  (miss_in),
        .wdata (lead_miss_addr),
        .pop   (hint_take),
        .rdata (hq_head),
        .empty (hq_empty),
        .full  (hq_full)
    );

    hint_port_arb #(.ADDR_W(ADDR_W)) u_arb (
        .dem_valid  (dem_valid),
        .dem_addr   (dem_addr),
        .hint_avail (~hq_empty),
        .hint_addr  (hq_head),
        .req_valid  (cache_req_valid),
        .req_addr   (cache_req_addr),
        .req_pf     (cache_req_pf),
        .hint_take  (hint_take)
    );

    // Purpose: count misses discarded on a full queue, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (miss_in && hq_full && drop_count != '1) begin
            drop_count <= drop_count + 1'b1;
        end
    end

    commit_cmp #(.TAG_W(TAG_W), .DATA_W(DATA_W), .DEPTH(CMT_DEPTH)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .lead_valid  (lead_cmt_valid & ~flush),
        .lead_tag    (lead_cmt_tag),
        .lead_data   (lead_cmt_data),
        .trail_valid (trail_cmt_valid & ~flush),
        .trail_tag   (trail_cmt_tag),
        .trail_data  (trail_cmt_data),
        .rollback    (rollback_req)
    );
endmodule

// File: rtl/miss_hint_fwd_chk.sv
// Port-level temporal checks for miss_hint_fwd, attached with bind.
module miss_hint_fwd_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              dem_valid,
    input logic [ADDR_W-1:0] dem_addr,
    input logic              cache_req_valid,
    input logic [ADDR_W-1:0] cache_req_addr,
    input logic              cache_req_pf,
    input logic [DROP_W-1:0] drop_count,
    input logic              rollback_req
);
    // R2
    demand_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid |-> (cache_req_valid && !cache_req_pf && cache_req_addr == dem_addr));

    // R4
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

    // R6
    rollback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback_req && !flush) |=> rollback_req);

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rollback_req && !cache_req_pf));

    // R9
    flush_keeps_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(drop_count));
endmodule

bind miss_hint_fwd miss_hint_fwd_chk #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush           (flush),
    .dem_valid       (dem_valid),
    .dem_addr        (dem_addr),
    .cache_req_valid (cache_req_valid),
    .cache_req_addr  (cache_req_addr),
    .cache_req_pf    (cache_req_pf),
    .drop_count      (drop_count),
    .rollback_req    (rollback_req)
);

// File: tb/miss_hint_fwd_tb.sv
// Scoreboard bench: the driver queues expected hint addresses, and the
// monitor pops and compares each hint as it appears on the cache port.
module miss_hint_fwd_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TW = 8;
    localparam int DRW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic lead_miss_valid = 1'b0;
    logic [AW-1:0] lead_miss_addr = '0;
    logic dem_valid = 1'b0;
    logic [AW-1:0] dem_addr = '0;
    logic cache_req_valid, cache_req_pf;
    logic [AW-1:0] cache_req_addr;
    logic [DRW-1:0] drop_count;
    logic lead_cmt_valid = 1'b0;
    logic [TW-1:0] lead_cmt_tag = '0;
    logic [DW-1:0] lead_cmt_data = '0;
    logic trail_cmt_valid = 1'b0;
    logic [TW-1:0] trail_cmt_tag = '0;
    logic [DW-1:0] trail_cmt_data = '0;
    logic rollback_req;

    int checks = 0;
    int fails = 0;
    int exp_drop = 0;
    logic [AW-1:0] exp_q [$];

    always #2 clk = ~clk;

    miss_hint_fwd u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lead_miss_valid(lead_miss_valid), .lead_miss_addr(lead_miss_addr),
        .dem_valid(dem_valid), .dem_addr(dem_addr),
        .cache_req_valid(cache_req_valid), .cache_req_addr(cache_req_addr),
        .cache_req_pf(cache_req_pf), .drop_count(drop_count),
        .lead_cmt_valid(lead_cmt_valid), .lead_cmt_tag(lead_cmt_tag),
        .lead_cmt_data(lead_cmt_data),
        .trail_cmt_valid(trail_cmt_valid), .trail_cmt_tag(trail_cmt_tag),
        .trail_cmt_data(trail_cmt_data), .rollback_req(rollback_req)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: present one miss for one cycle and record the expected outcome.
    task automatic send_miss(input logic [AW-1:0] a);
        step();
        lead_miss_valid = 1'b1;
        lead_miss_addr  = a;
        if (exp_q.size() < 8) exp_q.push_back(a);
        else exp_drop++;
        step();
        lead_miss_valid = 1'b0;
    endtask

    task automatic lead_commit(input logic [TW-1:0] t, input logic [DW-1:0] d);
        step();
        lead_cmt_valid = 1'b1; lead_cmt_tag = t; lead_cmt_data = d;
        step();
        lead_cmt_valid = 1'b0;
    endtask

    task automatic trail_commit(input logic [TW-1:0] t, input logic [DW-1:0] d);
        step();
        trail_cmt_valid = 1'b1; trail_cmt_tag = t; trail_cmt_data = d;
        step();
        trail_cmt_valid = 1'b0;
    endtask

    task automatic do_flush(input logic with_miss);
        step();
        flush = 1'b1;
        lead_miss_valid = with_miss;
        lead_miss_addr  = 32'hDEAD_0000;
        exp_q.delete();
        step();
        flush = 1'b0;
        lead_miss_valid = 1'b0;
    endtask

    // Monitor: compare every cycle's port contents away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dem_valid) begin
                check(cache_req_valid && !cache_req_pf && cache_req_addr == dem_addr,
                      "R2 demand passthrough", {31'd0, cache_req_pf, cache_req_addr},
                      {32'd0, dem_addr});
            end
            if (cache_req_pf) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected hint", {32'd0, cache_req_addr}, 64'd0);
                end else begin
                    logic [AW-1:0] e;
                    e = exp_q.pop_front();
                    check(cache_req_addr == e, "R1 hint order/address",
                          {32'd0, cache_req_addr}, {32'd0, e});
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        check(!cache_req_valid && !rollback_req && drop_count == 0, "R10 reset",
              {cache_req_valid, rollback_req, drop_count}, 64'd0);

        // R3: hint in the cycle after capture, issued once
        send_miss(32'h0000_1000);
        check(cache_req_pf && cache_req_addr == 32'h0000_1000, "R3 next-cycle hint",
              {32'd0, cache_req_addr}, 64'h1000);
        step();
        check(!cache_req_valid, "R3 single issue", {63'd0, cache_req_valid}, 64'd0);

        // R2/R1: demands hold hints back; hints follow in order
        dem_valid = 1'b1; dem_addr = 32'h0000_A000;
        send_miss(32'h0000_2000);
        send_miss(32'h0000_2040);
        dem_addr = 32'h0000_A040;
        send_miss(32'h0000_2080);
        check(exp_q.size() == 3, "R2 hints held", exp_q.size(), 64'd3);
        dem_valid = 1'b0;
        repeat (5) step();
        check(exp_q.size() == 0, "R1 all hints issued", exp_q.size(), 64'd0);

        // R4: overflow while the port is busy
        dem_valid = 1'b1;
        for (int i = 0; i < 10; i++) send_miss(32'h0001_0000 + 32'(i * 64));
        step();
        check(drop_count == DRW'(exp_drop) && exp_drop == 2, "R4 drop count",
              drop_count, exp_drop);
        dem_valid = 1'b0;
        repeat (10) step();
        check(exp_q.size() == 0, "R4 eight retained", exp_q.size(), 64'd0);

        // R9: flush discards queued hints and the concurrent miss
        dem_valid = 1'b1;
        send_miss(32'h0002_0000);
        send_miss(32'h0002_0040);
        do_flush(1'b1);
        dem_valid = 1'b0;
        step();
        check(!cache_req_valid, "R9 queue emptied", {63'd0, cache_req_valid}, 64'd0);
        repeat (3) step();
        check(drop_count == 16'd2, "R9 drop count kept", drop_count, 64'd2);

        // R5: matching commits
        lead_commit(8'd1, 32'h1111);
        lead_commit(8'd2, 32'h2222);
        trail_commit(8'd1, 32'h1111);
        trail_commit(8'd2, 32'h2222);
        check(!rollback_req, "R5 match no rollback", {63'd0, rollback_req}, 64'd0);

        // R6: value mismatch, sticky
        lead_commit(8'd3, 32'h3333);
        trail_commit(8'd3, 32'h3334);
        check(rollback_req, "R6 value mismatch", {63'd0, rollback_req}, 64'd1);
        repeat (4) step();
        check(rollback_req, "R6 sticky", {63'd0, rollback_req}, 64'd1);

        // R9: flush clears rollback and stale commits
        lead_commit(8'd9, 32'h9999);
        do_flush(1'b0);
        check(!rollback_req, "R9 rollback cleared", {63'd0, rollback_req}, 64'd0);
        lead_commit(8'd5, 32'h5555);
        trail_commit(8'd5, 32'h5555);
        check(!rollback_req, "R9 stale entries gone", {63'd0, rollback_req}, 64'd0);

        // R6: tag mismatch
        lead_commit(8'd6, 32'h6666);
        trail_commit(8'd7, 32'h6666);
        check(rollback_req, "R6 tag mismatch", {63'd0, rollback_req}, 64'd1);
        do_flush(1'b0);

        // R7: trailing commit with nothing waiting
        trail_commit(8'd8, 32'h8888);
        check(rollback_req, "R7 trail ahead", {63'd0, rollback_req}, 64'd1);
        do_flush(1'b0);

        // R8: commit buffer overflow
        for (int i = 0; i < 8; i++) lead_commit(TW'(i), DW'(i));
        check(!rollback_req, "R8 eight fit", {63'd0, rollback_req}, 64'd0);
        lead_commit(8'd8, 32'd8);
        check(rollback_req, "R8 overflow", {63'd0, rollback_req}, 64'd1);
        do_flush(1'b0);

        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule